// File: doc/BRIEF.md
# Banked Register-Mapped GPIO Controller

This block gives software control of a parameterised number of general-purpose pins through a 32-bit register read/write bus. Pins are grouped eight to a bank. Each bank owns two registers: one holds the output values and one holds the pin directions. The pins leave the block as an output-enable vector and an output-value vector. Pin levels come back in on an input vector, which is synchronised before it can be read.

Bank registers are not packed from address zero. The first bank starts one eight-byte stride up. A sixteen-byte window at 0x90..0x9F is skipped, so every register whose nominal address falls at or above 0x90 is moved sixteen bytes higher. A data read mixes two sources pin by pin. An input pin returns its live synchronised level. An output pin returns its output latch. Writes to the data register always load the latch. A value written while a pin is an input therefore drives the pin as soon as the pin is turned into an output.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin p is controlled and observed through bank p/8 at bit p%8 of that bank's registers.
- R2: Bank b has its data register at byte address N=(b+1)*8 and its direction register at N+4. When N is 0x90 or above, both addresses are moved 0x10 higher. Only exact addresses decode.
- R3: Reads of any address that is not a bank register return zero, and this includes 0x90..0x9F. Writes to such an address change no latch.
- R4: In the direction register, bit value 1 makes the pin an input and 0 makes it an output. pin_oe[p] is the inverse of pin p's direction bit.
- R5: Each bit of a data read is the synchronised pin level when that pin is an input, and the output latch when it is an output.
- R6: Every data-register write loads the output latches from wdata[7:0], whatever the pin directions are. pin_out always reflects the latches.
- R7: Read bits [31:8] are zero. Bits of pins beyond NUM_PINS in the last bank read zero in both registers and cannot be set. Write bits [31:8] are ignored.
- R8: After reset every implemented pin is an input, every latch is 0 and reg_rdata is 0.
- R9: A pin change reaches reg_rdata no earlier than three clock edges after it is applied: two synchroniser flops plus the read register.
- R10: reg_rdata is loaded on the clock edge at which reg_rd is high. It holds its value while reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value |

## Verification
Writes are visible on pin_oe and pin_out right after the edge that takes them, and read data appears one edge after the edge that sampled reg_rd. The bench drives at the falling edge and samples at the next falling edge. A pin change needs three edges to reach reg_rdata. After every change to pin_in the bench therefore waits four cycles before it reads. The one exception is the timing test, which reads at the second and third edge after the change and expects the old value and then the new value. Address sweeps cover every byte address of the 8-bit space.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int PINS_PER_BANK = 8;
    localparam int BANK_STRIDE   = 8;
    localparam int DIR_OFFSET    = 4;
    localparam int GAP_START     = 'h90;
    localparam int GAP_SIZE      = 'h10;

    // byte address of a bank's data register, including the skipped window
    function automatic int bank_base(input int bank);
        int a;
        a = (bank + 1) * BANK_STRIDE;
        if (a >= GAP_START) a = a + GAP_SIZE;
        return a;
    endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 18,
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_dir,
    output logic [IDX_W-1:0]  bank
);
    always_comb begin
        hit    = 1'b0;
        is_dir = 1'b0;
        bank   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(bank_base(b))) begin
                hit  = 1'b1;
                bank = IDX_W'(b);
            end
            if (addr == ADDR_W'(bank_base(b) + DIR_OFFSET)) begin
                hit    = 1'b1;
                is_dir = 1'b1;
                bank   = IDX_W'(b);
            end
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 140
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = d;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q = sync_q.s2;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 140,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [31:0]         reg_wdata,
    input  logic                reg_rd,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);
    localparam int NUM_BANKS = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;
    localparam int PAD_W     = NUM_BANKS * PINS_PER_BANK;
    localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    function automatic logic [PAD_W-1:0] impl_mask();
        logic [PAD_W-1:0] m;
        for (int i = 0; i < PAD_W; i++) m[i] = (i < NUM_PINS);
        return m;
    endfunction

    localparam logic [PAD_W-1:0] IMPL = impl_mask();

    typedef struct packed {
        logic [PAD_W-1:0] dir;   // 1 = input
        logic [PAD_W-1:0] lat;   // output latches
        logic [31:0]      rdata;
    } state_t;

    state_t s_d, s_q;

    logic              dec_hit;
    logic              dec_dir;
    logic [IDX_W-1:0]  dec_bank;
    logic [NUM_PINS-1:0] pin_sync;
    logic [PAD_W-1:0]  pin_pad;
    logic [PAD_W-1:0]  view;
    logic [7:0]        sel_byte;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata[31:8];

    gpio_addr_dec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr   (reg_addr),
        .hit    (dec_hit),
        .is_dir (dec_dir),
        .bank   (dec_bank)
    );

    gpio_in_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    always_comb begin
        s_d      = s_q;
        pin_pad  = PAD_W'(pin_sync);
        // inputs show the pin, outputs show the latch
        view     = (s_q.dir & pin_pad) | (~s_q.dir & s_q.lat);
        sel_byte = dec_dir ? s_q.dir[int'(dec_bank)*PINS_PER_BANK +: PINS_PER_BANK]
                           : view[int'(dec_bank)*PINS_PER_BANK +: PINS_PER_BANK];

        if (reg_wr && dec_hit) begin
            if (dec_dir)
                s_d.dir[int'(dec_bank)*PINS_PER_BANK +: PINS_PER_BANK] =
                    reg_wdata[7:0] & IMPL[int'(dec_bank)*PINS_PER_BANK +: PINS_PER_BANK];
            else
                s_d.lat[int'(dec_bank)*PINS_PER_BANK +: PINS_PER_BANK] =
                    reg_wdata[7:0] & IMPL[int'(dec_bank)*PINS_PER_BANK +: PINS_PER_BANK];
        end

        if (reg_rd)
            s_d.rdata = dec_hit ? {24'h0, sel_byte} : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.dir   <= IMPL;
            s_q.lat   <= '0;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata = s_q.rdata;
    assign pin_oe    = ~s_q.dir[NUM_PINS-1:0];
    assign pin_out   = s_q.lat[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_PINS = 140,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [31:0]         reg_rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out
);
    logic in_gap;
    assign in_gap = (reg_addr >= ADDR_W'('h90)) && (reg_addr <= ADDR_W'('h9F));

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0) && (pin_out == '0) && (reg_rdata == '0)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R10

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:8] == 24'h0); // R7

    AST_GAP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && in_gap) |=> (reg_rdata == 32'h0)); // R3

    AST_GAP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && in_gap) |=> ($stable(pin_oe) && $stable(pin_out))); // R3

    AST_IDLE_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(pin_oe) && $stable(pin_out))); // R6
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
    localparam int NP = 140;
    localparam int AW = 8;
    localparam int NB = (NP + 7) / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] pin_out;

    logic [NP-1:0] dir_m;
    logic [NP-1:0] lat_m;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    function automatic int base_of(input int b);
        int a;
        a = (b + 1) * 8;
        if (a >= 'h90) a = a + 'h10;
        return a;
    endfunction

    // 0 = unmapped, 1 = data, 2 = direction
    function automatic int kind_of(input int addr, output int bank);
        bank = 0;
        for (int b = 0; b < NB; b++) begin
            if (addr == base_of(b))     begin bank = b; return 1; end
            if (addr == base_of(b) + 4) begin bank = b; return 2; end
        end
        return 0;
    endfunction

    function automatic logic [31:0] exp_read(input int addr);
        int b, k;
        logic [31:0] r;
        r = '0;
        k = kind_of(addr, b);
        for (int i = 0; i < 8; i++) begin
            int p = b * 8 + i;
            if (k != 0 && p < NP) begin
                if (k == 2)         r[i] = dir_m[p];
                else if (dir_m[p])  r[i] = pin_in[p];
                else                r[i] = lat_m[p];
            end
        end
        return r;
    endfunction

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chkv(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        int b, k;
        @(negedge clk);
        reg_addr = AW'(addr); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        k = kind_of(addr, b);
        for (int i = 0; i < 8; i++) begin
            int p = b * 8 + i;
            if (p < NP) begin
                if (k == 1) lat_m[p] = d[i];
                if (k == 2) dir_m[p] = d[i];
            end
        end
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(addr); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic sweep_reads();
        logic [31:0] d;
        int b, k;
        for (int a = 0; a < 256; a++) begin
            rd(a, d);
            k = kind_of(a, b);
            chk32(k == 1 ? "R5 data read" : (k == 2 ? "R2 dir read" : "R3 unmapped read"),
                  d, exp_read(a));
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        dir_m = '1; lat_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chkv("R8 pin_oe reset", pin_oe, '0);
        chkv("R8 pin_out reset", pin_out, '0);
        chk32("R8 rdata reset", reg_rdata, '0);

        // R2/R3/R7 sweep with a pin pattern, all pins input
        for (int p = 0; p < NP; p++) pin_in[p] = ((p * 7 + 3) % 5) < 2;
        settle();
        sweep_reads();

        // R3 writes to every unmapped address do nothing
        for (int a = 0; a < 256; a++) begin
            int b;
            if (kind_of(a, b) == 0) wr(a, 32'hFFFF_FFFF);
        end
        chkv("R3 pin_oe after unmapped writes", pin_oe, '0);
        chkv("R3 pin_out after unmapped writes", pin_out, '0);

        // R6 latch writes while inputs; R7 upper wdata bits ignored
        for (int b = 0; b < NB; b++) wr(base_of(b), 32'hFFFF_FF00 | 32'((8'h5A ^ (b * 13)) & 8'hFF));
        chkv("R6 pin_out follows latch while input", pin_out, lat_m);
        chkv("R4 pins stay inputs", pin_oe, '0);
        sweep_reads();

        // R4/R5 mixed directions
        for (int b = 0; b < NB; b++) wr(base_of(b) + 4, 32'hFFFF_FF00 | 32'((8'h33 + b * 29) & 8'hFF));
        chkv("R4 pin_oe inverse of dir", pin_oe, ~dir_m);
        chkv("R6 pin_out keeps latch", pin_out, lat_m);
        for (int p = 0; p < NP; p++) pin_in[p] = ((p * 11 + 1) % 3) == 0;
        settle();
        sweep_reads();

        // R7 last bank unimplemented bits
        wr(base_of(NB - 1) + 4, 32'hFF);
        rd(base_of(NB - 1) + 4, d);
        chk32("R7 last bank dir width", d, 32'h0F);
        wr(base_of(NB - 1), 32'hFF);
        wr(base_of(NB - 1) + 4, 32'h00);
        rd(base_of(NB - 1), d);
        chk32("R7 last bank data width", d, 32'h0F);

        // R6 value written while input appears when switched to output
        wr(base_of(0) + 4, 32'hFF);
        wr(base_of(0), 32'hC3);
        pin_in[7:0] = 8'h18;
        settle();
        rd(base_of(0), d);
        chk32("R6 input read ignores latch", d, 32'h18);
        wr(base_of(0) + 4, 32'h00);
        rd(base_of(0), d);
        chk32("R6 latched value after switch to output", d, 32'hC3);
        chk32("R6 pin_out bank0", 32'(pin_out[7:0]), 32'hC3);

        // R1 walking single pin, all inputs
        for (int b = 0; b < NB; b++) wr(base_of(b) + 4, 32'hFF);
        for (int p = 0; p < NP; p++) begin
            pin_in = '0;
            pin_in[p] = 1'b1;
            settle();
            rd(base_of(p / 8), d);
            chk32("R1 pin to bank bit", d, 32'(1) << (p % 8));
        end

        // R9 synchroniser latency
        pin_in = '0;
        settle();
        @(negedge clk);
        pin_in[3] = 1'b1; reg_addr = AW'(base_of(0)); reg_rd = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk32("R9 old level at second edge", reg_rdata, 32'h0);
        @(negedge clk);
        chk32("R9 new level at third edge", reg_rdata, 32'h08);
        reg_rd = 1'b0;

        // R10 rdata holds without a read
        pin_in[3] = 1'b0;
        settle();
        chk32("R10 rdata held", reg_rdata, 32'h08);
        rd(base_of(0), d);
        chk32("R10 rdata reloaded", d, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule